// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block keeps one processor's small direct-mapped cache coherent with its peers on a shared, atomic bus. Every line carries one of four tags: invalid, valid (clean, possibly shared), reserved (written once, written through, so memory matches and no other cache holds it), and dirty (written more than once, the only current copy). The first write to a clean shared line is broadcast as an invalidation and written through to memory. Writes after that stay inside the cache.

The processor side is a request/acknowledge port. On the bus side the block requests ownership from an external arbiter. When granted, it issues one command, and for a fetch it keeps the bus until the line arrives on the fill input. Transactions from other caches come in on the snoop inputs. The block answers a snooped fetch of a dirty line one cycle later: it supplies the data on the supply output and updates memory through the memory-update port. That same port carries its own write-throughs and victim write-backs.

Top module: `wo_coh_ctrl`

## Requirements
- R1: Bus commands are encoded as 0 write-back, 1 read, 2 read-invalidate, 3 write-invalidate. After reset every line is invalid, so the first read of any address issues a read command (1), and no output is asserted.
- R2: A read hit is acknowledged one cycle after it is accepted, with the line data on `cpu_rdata`. It raises no bus request and leaves the line's state unchanged.
- R3: A read miss issues a read command (1) for the address and keeps `bus_req` high until `fill_valid`. It returns `fill_data` to the processor and leaves the line valid, so a later read hits.
- R4: A write hit on a valid line issues write-invalidate (3). In the next cycle it writes the data through on the memory port and acknowledges. The line becomes reserved.
- R5: A write hit on a reserved or dirty line completes with no bus request and no memory write. The line becomes dirty.
- R6: A write miss issues read-invalidate (2), waits for the fill, and stores the processor's data, not the fill. The line becomes dirty and no memory write is made.
- R7: A snooped read (1) that hits a dirty line puts the line data on `sup_data` with `sup_valid`, and writes it to memory at the snooped address, in the cycle after the snoop. The line becomes valid.
- R8: A snooped read-invalidate (2) that hits a dirty line supplies the data and updates memory in the same way. The line becomes invalid.
- R9: A snooped read-invalidate or write-invalidate that hits a valid or reserved line invalidates it without supplying data. A snooped read on a reserved line makes it valid. A snooped write-back (0) or a snoop that misses has no effect.
- R10: A miss whose victim line is dirty first issues a write-back (0) of the victim's address and writes the victim data to memory. Only then does it issue the fetch.
- R11: If a valid line waiting to be upgraded is invalidated by a snoop before the grant arrives, the write is issued as read-invalidate (2) instead of write-invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` on reads |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Grant from the arbiter, kept while `bus_req` is high |
| mst_valid | output | 1 | This cache drives a command this cycle |
| mst_cmd | output | 2 | Command issued |
| mst_addr | output | AW | Address issued |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped address |
| fill_valid | input | 1 | Line data for this cache's fetch |
| fill_data | input | DW | Fetched data |
| sup_valid | output | 1 | This cache supplies a dirty line |
| sup_data | output | DW | Supplied data |
| mem_wr | output | 1 | Memory update strobe |
| mem_addr | output | AW | Memory update address |
| mem_wdata | output | DW | Memory update data |

## Verification
A wrong line tag shows up only on the next access to that line, so each slip is exposed by a later transaction. A line left valid when it should be reserved shows as an extra write-invalidate on the next write. A line left dirty when it should be clean shows as a spurious write-back or a data supply on the next miss or snoop. A stale tag after a snoop invalidation shows as a missing fetch. The bench keeps its own tag model and compares the command sequence, memory updates and data of every operation. A divergence is therefore caught within the first operation or snoop that touches the affected line.

// File: rtl/wo_coh_ctrl.sv
module wo_coh_ctrl #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mst_valid,
  output logic [1:0]    mst_cmd,
  output logic [AW-1:0] mst_addr,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  output logic          sup_valid,
  output logic [DW-1:0] sup_data,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  localparam logic [1:0] LS_I = 2'd0, LS_V = 2'd1, LS_R = 2'd2, LS_D = 2'd3;
  localparam logic [1:0] CMD_WB = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WINV = 2'd3;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_REQ, F_WAIT} fsm_t;
  fsm_t fsm;

  logic [1:0]    lst  [LINES];
  logic [TW-1:0] ltag [LINES];
  logic [DW-1:0] ldat [LINES];

  logic          p_we;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;

  logic [IW-1:0] c_idx, s_idx, p_idx;
  logic          c_hit, s_hit, p_same, upg_ok, accept;
  logic [1:0]    c_st, s_st, p_st;

  assign c_idx  = cpu_addr[IW-1:0];
  assign s_idx  = snp_addr[IW-1:0];
  assign p_idx  = p_addr[IW-1:0];
  assign c_st   = lst[c_idx];
  assign s_st   = lst[s_idx];
  assign p_st   = lst[p_idx];
  assign c_hit  = (c_st != LS_I) && (ltag[c_idx] == cpu_addr[AW-1:IW]);
  assign s_hit  = (s_st != LS_I) && (ltag[s_idx] == snp_addr[AW-1:IW]);
  assign p_same = ltag[p_idx] == p_addr[AW-1:IW];
  assign upg_ok = (p_st == LS_V) && p_same;
  assign accept = (fsm == F_IDLE) && cpu_req && !(snp_valid && (s_idx == c_idx));

  assign bus_req   = fsm != F_IDLE;
  assign mst_valid = bus_gnt && ((fsm == F_REQ) || (fsm == F_WB && p_st == LS_D));
  assign mst_cmd   = (fsm == F_WB) ? CMD_WB : !p_we ? CMD_RD : upg_ok ? CMD_WINV : CMD_RDX;
  assign mst_addr  = (fsm == F_WB) ? {ltag[p_idx], p_idx} : p_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      cpu_ack   <= 1'b0;
      sup_valid <= 1'b0;
      mem_wr    <= 1'b0;
      for (int i = 0; i < LINES; i++) lst[i] <= LS_I;
    end else begin
      cpu_ack   <= 1'b0;
      sup_valid <= 1'b0;
      mem_wr    <= 1'b0;

      if (snp_valid && s_hit && snp_cmd != CMD_WB) begin
        if (s_st == LS_D && snp_cmd != CMD_WINV) begin
          sup_valid <= 1'b1;
          sup_data  <= ldat[s_idx];
          mem_wr    <= 1'b1;
          mem_addr  <= snp_addr;
          mem_wdata <= ldat[s_idx];
        end
        if (snp_cmd == CMD_RD) lst[s_idx] <= LS_V;
        else                   lst[s_idx] <= LS_I;
      end

      case (fsm)
        F_IDLE: if (accept) begin
          p_we    <= cpu_we;
          p_addr  <= cpu_addr;
          p_wdata <= cpu_wdata;
          if (c_hit && !cpu_we) begin
            cpu_rdata <= ldat[c_idx];
            cpu_ack   <= 1'b1;
          end else if (c_hit && c_st != LS_V) begin
            ldat[c_idx] <= cpu_wdata;
            lst[c_idx]  <= LS_D;
            cpu_ack     <= 1'b1;
          end else if (c_hit) begin
            fsm <= F_REQ;
          end else begin
            fsm <= (c_st == LS_D) ? F_WB : F_REQ;
          end
        end
        F_WB: begin
          if (p_st != LS_D) fsm <= F_REQ;
          else if (bus_gnt) begin
            mem_wr     <= 1'b1;
            mem_addr   <= {ltag[p_idx], p_idx};
            mem_wdata  <= ldat[p_idx];
            lst[p_idx] <= LS_I;
            fsm        <= F_REQ;
          end
        end
        F_REQ: if (bus_gnt) begin
          if (p_we && upg_ok) begin
            ldat[p_idx] <= p_wdata;
            lst[p_idx]  <= LS_R;
            mem_wr      <= 1'b1;
            mem_addr    <= p_addr;
            mem_wdata   <= p_wdata;
            cpu_ack     <= 1'b1;
            fsm         <= F_IDLE;
          end else begin
            fsm <= F_WAIT;
          end
        end
        F_WAIT: if (fill_valid) begin
          ltag[p_idx] <= p_addr[AW-1:IW];
          cpu_ack     <= 1'b1;
          fsm         <= F_IDLE;
          if (p_we) begin
            ldat[p_idx] <= p_wdata;
            lst[p_idx]  <= LS_D;
          end else begin
            ldat[p_idx] <= fill_data;
            lst[p_idx]  <= LS_V;
            cpu_rdata   <= fill_data;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wo_coh_chk.sv
module wo_coh_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mst_valid,
  input logic [1:0]    mst_cmd,
  input logic [AW-1:0] mst_addr,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          cpu_ack,
  input logic          sup_valid,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd
);
  p_issue_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid |-> (bus_gnt && bus_req));

  p_fetch_holds_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && (mst_cmd == 2'd1 || mst_cmd == 2'd2)) |=> (bus_req && !cpu_ack));

  p_write_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && mst_cmd == 2'd3) |=> (mem_wr && mem_addr == $past(mst_addr) && cpu_ack));

  p_supply_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sup_valid |-> ($past(snp_valid) && ($past(snp_cmd) == 2'd1 || $past(snp_cmd) == 2'd2)));

  p_winv_no_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd3) |=> !sup_valid);

  p_victim_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && mst_cmd == 2'd0) |=> (mem_wr && mem_addr == $past(mst_addr) && !cpu_ack));
endmodule

bind wo_coh_ctrl wo_coh_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mst_valid(mst_valid), .mst_cmd(mst_cmd), .mst_addr(mst_addr),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .cpu_ack(cpu_ack),
  .sup_valid(sup_valid), .snp_valid(snp_valid), .snp_cmd(snp_cmd)
);

// File: tb/sim_wo_coh_ctrl.sv
module sim_wo_coh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 32, LINES = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ack, bus_req, mst_valid, sup_valid, mem_wr;
  logic [DW-1:0] cpu_rdata, sup_data, mem_wdata;
  logic bus_gnt = 0, snp_valid = 0, fill_valid = 0;
  logic [1:0] mst_cmd;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] mst_addr, mem_addr;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] fill_data = '0;

  wo_coh_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mst_valid(mst_valid), .mst_cmd(mst_cmd), .mst_addr(mst_addr),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .fill_valid(fill_valid),
    .fill_data(fill_data), .sup_valid(sup_valid), .sup_data(sup_data), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [1:0]    m_st  [LINES];
  logic [AW-3:0] m_tag [LINES];
  logic [DW-1:0] m_dat [LINES];

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit steal, input string force_tag);
    logic [1:0] idx;
    logic [AW-3:0] tg;
    bit hit, done, fill_pend, got_mw;
    int n, gn, iter, gcnt, fcnt;
    logic [1:0] ecmd [2];
    logic [AW-1:0] eaddr [2];
    logic [1:0] gcmd [4];
    logic [AW-1:0] gaddr [4];
    bit emw;
    logic [AW-1:0] ema, gma;
    logic [DW-1:0] emd, gmd, fval, erd, grd;
    string t;
    idx = a[1:0]; tg = a[AW-1:2];
    n = 0; gn = 0; emw = 0; got_mw = 0; ema = '0; emd = '0; gma = '0; gmd = '0;
    erd = '0; grd = '0;
    fval = $urandom;
    if (steal && m_st[idx] == 2'd1 && m_tag[idx] == tg) m_st[idx] = 2'd0;
    hit = (m_st[idx] != 2'd0) && (m_tag[idx] == tg);
    if (hit && !we) begin
      t = "R2"; erd = m_dat[idx];
    end else if (hit && m_st[idx] != 2'd1) begin
      t = "R5"; m_st[idx] = 2'd3; m_dat[idx] = wd;
    end else if (hit) begin
      t = "R4"; n = 1; ecmd[0] = 2'd3; eaddr[0] = a; emw = 1; ema = a; emd = wd;
      m_st[idx] = 2'd2; m_dat[idx] = wd;
    end else begin
      t = we ? "R6" : "R3";
      if (m_st[idx] == 2'd3) begin
        t = "R10"; ecmd[0] = 2'd0; eaddr[0] = {m_tag[idx], idx};
        emw = 1; ema = {m_tag[idx], idx}; emd = m_dat[idx]; n = 1;
      end
      ecmd[n] = we ? 2'd2 : 2'd1; eaddr[n] = a; n++;
      m_tag[idx] = tg;
      if (we) begin m_st[idx] = 2'd3; m_dat[idx] = wd; end
      else begin m_st[idx] = 2'd1; m_dat[idx] = fval; erd = fval; end
    end
    if (steal) t = "R11";
    if (force_tag != "") t = force_tag;

    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    done = 0; fill_pend = 0; iter = 0; fcnt = 0;
    gcnt = steal ? 3 : int'($urandom % 3);
    while (!done && iter < 60) begin
      @(negedge clk); iter++;
      snp_valid = 0;
      if (mem_wr) begin got_mw = 1; gma = mem_addr; gmd = mem_wdata; end
      if (cpu_ack) begin
        done = 1; cpu_req = 0; grd = cpu_rdata; bus_gnt = 0; fill_valid = 0;
      end else begin
        fill_valid = 0;
        if (fill_pend) begin
          if (fcnt == 0) begin fill_valid = 1; fill_data = fval; fill_pend = 0; end
          else fcnt--;
        end
        if (bus_req) begin
          if (!bus_gnt) begin
            if (gcnt == 0) bus_gnt = 1; else gcnt--;
          end
        end else bus_gnt = 0;
        if (steal && iter == 1) begin snp_valid = 1; snp_cmd = 2'd3; snp_addr = a; end
        #1;
        if (mst_valid) begin
          if (gn < 4) begin gcmd[gn] = mst_cmd; gaddr[gn] = mst_addr; end
          gn++;
          if (mst_cmd == 2'd1 || mst_cmd == 2'd2) begin
            fill_pend = 1; fcnt = int'($urandom % 3);
          end
        end
      end
    end
    if (!done) begin cpu_req = 0; bus_gnt = 0; fill_valid = 0; end
    chk(done, t, "operation acknowledged", 64'(done), 64'd1);
    chk(gn == n, t, "bus command count", 64'(gn), 64'(n));
    for (int k = 0; k < 2; k++)
      if (k < n && k < gn) begin
        chk(gcmd[k] == ecmd[k], t, "bus command", 64'(gcmd[k]), 64'(ecmd[k]));
        chk(gaddr[k] == eaddr[k], t, "bus address", 64'(gaddr[k]), 64'(eaddr[k]));
      end
    chk(got_mw == emw, t, "memory write present", 64'(got_mw), 64'(emw));
    if (emw && got_mw) begin
      chk(gma == ema, t, "memory write address", 64'(gma), 64'(ema));
      chk(gmd == emd, t, "memory write data", 64'(gmd), 64'(emd));
    end
    if (!we) chk(grd == erd, t, "read data", 64'(grd), 64'(erd));
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
    logic [1:0] idx;
    bit hit, esup;
    logic [DW-1:0] ed;
    string t;
    idx = a[1:0];
    hit = (m_st[idx] != 2'd0) && (m_tag[idx] == a[AW-1:2]);
    esup = 0; ed = m_dat[idx]; t = "R9";
    if (hit && c != 2'd0) begin
      if (m_st[idx] == 2'd3 && c != 2'd3) begin esup = 1; t = (c == 2'd1) ? "R7" : "R8"; end
      m_st[idx] = (c == 2'd1) ? 2'd1 : 2'd0;
    end
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    chk(sup_valid == esup, t, "supply strobe", 64'(sup_valid), 64'(esup));
    chk(mem_wr == esup, t, "memory update strobe", 64'(mem_wr), 64'(esup));
    if (esup && sup_valid) begin
      chk(sup_data == ed, t, "supplied data", 64'(sup_data), 64'(ed));
      chk(mem_addr == a && mem_wdata == ed, t, "memory update", 64'(mem_wdata), 64'(ed));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < LINES; i++) begin m_st[i] = 2'd0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_ack && !bus_req && !mst_valid && !sup_valid && !mem_wr, "R1",
        "outputs idle after reset",
        64'({cpu_ack, bus_req, mst_valid, sup_valid, mem_wr}), 64'd0);

    cpu_op(0, 8'h03, '0, 0, "R1");
    cpu_op(0, 8'h03, '0, 0, "");
    cpu_op(1, 8'h03, 32'hA1A1_0001, 0, "");
    cpu_op(1, 8'h03, 32'hA1A1_0002, 0, "");
    cpu_op(0, 8'h03, '0, 0, "");
    snoop(2'd1, 8'h03);
    cpu_op(1, 8'h03, 32'hB2B2_0003, 0, "");
    snoop(2'd1, 8'h03);
    cpu_op(1, 8'h03, 32'hB2B2_0004, 0, "");
    cpu_op(1, 8'h03, 32'hB2B2_0005, 0, "");
    snoop(2'd2, 8'h07);
    cpu_op(1, 8'h13, 32'hC3C3_0006, 0, "");
    cpu_op(1, 8'h23, 32'hC3C3_0007, 0, "");
    snoop(2'd2, 8'h23);
    cpu_op(0, 8'h23, '0, 0, "");
    snoop(2'd3, 8'h23);
    cpu_op(0, 8'h05, '0, 0, "");
    snoop(2'd0, 8'h05);
    cpu_op(0, 8'h05, '0, 0, "");
    cpu_op(1, 8'h05, 32'hD4D4_0008, 1, "");
    cpu_op(0, 8'h05, '0, 0, "");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ra;
      logic [1:0] rc;
      ra = AW'($urandom % 16);
      if ($urandom % 4 == 0) begin
        rc = 2'($urandom % 4);
        if (rc == 2'd3 && m_st[ra[1:0]] == 2'd3 && m_tag[ra[1:0]] == ra[AW-1:2]) rc = 2'd1;
        snoop(rc, ra);
      end else begin
        cpu_op(1'($urandom % 2), ra, $urandom, 0, "");
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule